// File: doc/BRIEF.md
# Scaled-index effective address generator

This unit turns the operand-addressing bytes of a 32-bit instruction into a memory address. It takes the addressing-form byte, an optional scale-index byte and an optional displacement, and reads up to two registers through a combinational read interface: one port for the base and one for the index. From these it works out whether the operand is really a register, what the effective address is (base + index × scale + displacement), and how many extra bytes the instruction carries after the form byte. A length decoder can use that last value.

Input arrives through a valid/ready handshake. The result is registered and comes back one cycle after acceptance, with a valid flag. Several register codes are reused to select other addressing forms: an absolute-address form, the form where a scale-index byte follows, and a "no index" code.

Top module: `operand_addr_gen`

## Requirements
- R1: When the form byte's top two bits (7:6) are 11, the operand is a register. In that case `out_is_reg` is 1, `out_reg_idx` equals form bits 2:0, `out_ea` is 0 and `out_extra_len` is 0, whatever the value of bits 2:0.
- R2: Form bits 7:6 select the displacement: 00 gives none, 01 gives 8 bits and 10 gives 32 bits. An 8-bit displacement is taken from `in_disp[7:0]` and sign-extended, and the upper input bits are ignored. Each displacement byte adds to `out_extra_len` (0, 1 or 4).
- R3: With form bits 7:6 = 00 and bits 2:0 = 101, no base register is used and the address is the 32-bit displacement, with `out_extra_len` = 4.
- R4: With form bits 2:0 = 100 and bits 7:6 other than 11, a scale-index byte follows. That byte counts 1 toward `out_extra_len`.
- R5: In the scale-index byte, bits 7:6 are the scale, bits 5:3 the index register and bits 2:0 the base register. Scale codes 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8.
- R6: An index code of 100 means no index term. This also leaves register 4 usable as a base.
- R7: When a scale-index byte is present, form bits 7:6 = 00 and base code = 101, there is no base term and a 32-bit displacement is added (`out_extra_len` = 5).
- R8: All address arithmetic wraps modulo 2^32.
- R9: `in_ready` is low during reset and high from the first clock edge after reset release. A transfer happens when `in_valid` and `in_ready` are both high, and `out_valid` is high in the cycle after a transfer and low otherwise.
- R10: In a cycle with no transfer, `out_ea`, `out_extra_len`, `out_is_reg` and `out_reg_idx` keep their values.
- R11: In reset, `out_valid` is 0, and an `in_valid` held during reset is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bytes are valid |
| in_ready | output | 1 | Unit accepts input |
| in_form | input | 8 | Addressing-form byte |
| in_sidx | input | 8 | Scale-index byte (used only when the form calls for it) |
| in_disp | input | AW | Displacement (low byte only for 8-bit forms) |
| rf_a_sel | output | 3 | Base register read select |
| rf_a_data | input | AW | Base register read data |
| rf_b_sel | output | 3 | Index register read select |
| rf_b_data | input | AW | Index register read data |
| out_valid | output | 1 | Result valid |
| out_is_reg | output | 1 | Operand is a register |
| out_reg_idx | output | 3 | Register number for the register form |
| out_ea | output | AW | Effective address |
| out_extra_len | output | 3 | Bytes following the form byte: scale-index byte plus displacement |

## Verification
The bench builds the unit with its default address width of 32, which is the width the sign extension and the 2^32 wrap are defined for. At that width, a negative 8-bit displacement, a wrap past the top of the address space and a 32-bit displacement of all ones can each be checked directly against hand-computed addresses. The bench register model returns a distinct value for every register number, so a wrong base or index select changes the address that comes out.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    DSP_NONE = 2'd0,
    DSP_B8   = 2'd1,
    DSP_B32  = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic       is_reg;
    logic       has_base;
    logic [2:0] base_sel;
    logic       has_index;
    logic [2:0] index_sel;
    logic [1:0] scale;
    disp_kind_e disp_kind;
    logic [2:0] extra_len;
  } ea_form_t;

  localparam logic [1:0] MOD_REG  = 2'b11;
  localparam logic [2:0] CODE_ESC = 3'b100;
  localparam logic [2:0] CODE_ABS = 3'b101;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [7:0] form_byte,
  input  logic [7:0] sidx_byte,
  output ea_form_t   form
);
  logic [1:0] md;
  logic [2:0] rm;
  logic       sidx_here;
  logic [2:0] disp_bytes;

  assign md = form_byte[7:6];
  assign rm = form_byte[2:0];

  always_comb begin
    form       = '0;
    sidx_here  = 1'b0;
    disp_bytes = 3'd0;
    if (md == MOD_REG) begin
      form.is_reg   = 1'b1;
      form.base_sel = rm;
    end else begin
      case (md)
        2'b01:   form.disp_kind = DSP_B8;
        2'b10:   form.disp_kind = DSP_B32;
        default: form.disp_kind = DSP_NONE;
      endcase
      if (rm == CODE_ESC) begin
        sidx_here       = 1'b1;
        form.scale      = sidx_byte[7:6];
        form.index_sel  = sidx_byte[5:3];
        form.has_index  = (sidx_byte[5:3] != CODE_ESC);
        form.base_sel   = sidx_byte[2:0];
        if (md == 2'b00 && sidx_byte[2:0] == CODE_ABS) begin
          form.has_base  = 1'b0;
          form.disp_kind = DSP_B32;
        end else begin
          form.has_base  = 1'b1;
        end
      end else if (md == 2'b00 && rm == CODE_ABS) begin
        form.has_base  = 1'b0;
        form.disp_kind = DSP_B32;
      end else begin
        form.has_base = 1'b1;
        form.base_sel = rm;
      end
      case (form.disp_kind)
        DSP_B8:  disp_bytes = 3'd1;
        DSP_B32: disp_bytes = 3'd4;
        default: disp_bytes = 3'd0;
      endcase
      form.extra_len = disp_bytes + {2'b00, sidx_here};
    end
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  ea_form_t        form,
  input  logic [AW-1:0]   base_val,
  input  logic [AW-1:0]   index_val,
  input  logic [AW-1:0]   disp_raw,
  output logic [AW-1:0]   ea
);
  localparam int NSCALE = 4;

  logic [AW-1:0] scaled [NSCALE];
  logic [AW-1:0] base_term;
  logic [AW-1:0] index_term;
  logic [AW-1:0] disp_term;

  for (genvar k = 0; k < NSCALE; k++) begin : g_scale
    assign scaled[k] = index_val << k;
  end

  always_comb begin
    base_term  = form.has_base  ? base_val : '0;
    index_term = form.has_index ? scaled[form.scale] : '0;
    case (form.disp_kind)
      DSP_B8:  disp_term = {{(AW-8){disp_raw[7]}}, disp_raw[7:0]};
      DSP_B32: disp_term = disp_raw;
      default: disp_term = '0;
    endcase
    ea = base_term + index_term + disp_term;
  end
endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_form,
  input  logic [7:0]    in_sidx,
  input  logic [AW-1:0] in_disp,
  output logic [2:0]    rf_a_sel,
  input  logic [AW-1:0] rf_a_data,
  output logic [2:0]    rf_b_sel,
  input  logic [AW-1:0] rf_b_data,
  output logic          out_valid,
  output logic          out_is_reg,
  output logic [2:0]    out_reg_idx,
  output logic [AW-1:0] out_ea,
  output logic [2:0]    out_extra_len
);
  ea_form_t      form;
  logic [AW-1:0] ea_comb;
  logic          fire;
  logic          rdy_q;

  logic          vld_d;
  logic          isr_d;
  logic [2:0]    ridx_d;
  logic [AW-1:0] ea_d;
  logic [2:0]    len_d;

  ea_decode u_dec (
    .form_byte (in_form),
    .sidx_byte (in_sidx),
    .form      (form)
  );

  assign rf_a_sel = form.base_sel;
  assign rf_b_sel = form.index_sel;

  ea_sum #(.AW(AW)) u_sum (
    .form      (form),
    .base_val  (rf_a_data),
    .index_val (rf_b_data),
    .disp_raw  (in_disp),
    .ea        (ea_comb)
  );

  assign in_ready = rdy_q;
  assign fire     = in_valid & rdy_q;

  always_comb begin
    vld_d  = fire;
    isr_d  = out_is_reg;
    ridx_d = out_reg_idx;
    ea_d   = out_ea;
    len_d  = out_extra_len;
    if (fire) begin
      isr_d  = form.is_reg;
      ridx_d = form.is_reg ? form.base_sel : 3'd0;
      ea_d   = ea_comb;
      len_d  = form.extra_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q         <= 1'b0;
      out_valid     <= 1'b0;
      out_is_reg    <= 1'b0;
      out_reg_idx   <= 3'd0;
      out_ea        <= '0;
      out_extra_len <= 3'd0;
    end else begin
      rdy_q         <= 1'b1;
      out_valid     <= vld_d;
      out_is_reg    <= isr_d;
      out_reg_idx   <= ridx_d;
      out_ea        <= ea_d;
      out_extra_len <= len_d;
    end
  end

  a_r1_reg_form: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_form[7:6] == 2'b11)
      |=> (out_is_reg && out_ea == '0 && out_extra_len == 3'd0));

  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_extra_len <= 3'd5));

  a_r4_sidx_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_form[7:6] != 2'b11 && in_form[2:0] == 3'b100)
      |=> (out_extra_len != 3'd0 && !out_is_reg));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(out_ea) && $stable(out_extra_len)
                                 && $stable(out_is_reg)));
endmodule

// File: tb/sim_operand_addr_gen.sv
`timescale 1ns/1ps
module sim_operand_addr_gen;
  localparam int AW = 32;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [7:0]    in_form;
  logic [7:0]    in_sidx;
  logic [AW-1:0] in_disp;
  logic [2:0]    rf_a_sel;
  logic [AW-1:0] rf_a_data;
  logic [2:0]    rf_b_sel;
  logic [AW-1:0] rf_b_data;
  logic          out_valid;
  logic          out_is_reg;
  logic [2:0]    out_reg_idx;
  logic [AW-1:0] out_ea;
  logic [2:0]    out_extra_len;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] rfv(input logic [2:0] s);
    return (32'(s) + 32'd1) << 8;
  endfunction

  assign rf_a_data = rfv(rf_a_sel);
  assign rf_b_data = rfv(rf_b_sel);

  operand_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_form(in_form), .in_sidx(in_sidx), .in_disp(in_disp),
    .rf_a_sel(rf_a_sel), .rf_a_data(rf_a_data),
    .rf_b_sel(rf_b_sel), .rf_b_data(rf_b_data),
    .out_valid(out_valid), .out_is_reg(out_is_reg), .out_reg_idx(out_reg_idx),
    .out_ea(out_ea), .out_extra_len(out_extra_len)
  );

  // {form, sidx, disp, is_reg, reg_idx, ea, len}; register n reads (n+1)*0x100
  localparam logic [86:0] VEC [NV] = '{
    {8'hC3, 8'h00, 32'h0000_0000, 1'b1, 3'd3, 32'h0000_0000, 3'd0}, // R1
    {8'h00, 8'h00, 32'h0000_0000, 1'b0, 3'd0, 32'h0000_0100, 3'd0}, // R2
    {8'h05, 8'h00, 32'h1234_5678, 1'b0, 3'd0, 32'h1234_5678, 3'd4}, // R3
    {8'h43, 8'h00, 32'hABCD_EF80, 1'b0, 3'd0, 32'h0000_0380, 3'd1}, // R2 neg d8
    {8'h45, 8'h00, 32'h0000_007F, 1'b0, 3'd0, 32'h0000_067F, 3'd1}, // R2
    {8'h86, 8'h00, 32'hFFFF_F000, 1'b0, 3'd0, 32'hFFFF_F700, 3'd4}, // R2
    {8'h04, 8'h88, 32'h0000_0000, 1'b0, 3'd0, 32'h0000_0900, 3'd1}, // R4 R5 x4
    {8'h04, 8'hC5, 32'h0000_1000, 1'b0, 3'd0, 32'h0000_1800, 3'd5}, // R7 x8
    {8'h44, 8'h65, 32'h0000_0010, 1'b0, 3'd0, 32'h0000_0610, 3'd2}, // R6
    {8'h84, 8'h3A, 32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0000_0AFF, 3'd5}, // R5 x1 R8
    {8'h04, 8'h25, 32'hDEAD_0000, 1'b0, 3'd0, 32'hDEAD_0000, 3'd5}, // R7 R6
    {8'h04, 8'h64, 32'h0000_0000, 1'b0, 3'd0, 32'h0000_0500, 3'd1}, // R6 base 4
    {8'h84, 8'hC7, 32'hFFFF_FF00, 1'b0, 3'd0, 32'h0000_0F00, 3'd5}, // R8 wrap
    {8'hE4, 8'hFF, 32'hFFFF_FFFF, 1'b1, 3'd4, 32'h0000_0000, 3'd0}, // R1 code 100
    {8'h4C, 8'h4E, 32'h0000_00FE, 1'b0, 3'd0, 32'h0000_0AFE, 3'd2}  // R5 x2
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_ea;
    logic [2:0]  last_len;
    rst_n = 1'b0; in_valid = 1'b1; in_form = 8'h00; in_sidx = 8'h00; in_disp = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b0, "R9 ready in reset", 32'(in_ready), 32'd0);
    chk(out_ea == '0, "R11 ea in reset", out_ea, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R9 idle valid", 32'(out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [86:0] v;
      v = VEC[i];
      in_form = v[86:79]; in_sidx = v[78:71]; in_disp = v[70:39]; in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b1, "R9 valid after transfer", 32'(out_valid), 32'd1);
      chk(out_is_reg == v[38], "R1 is_reg", 32'(out_is_reg), 32'(v[38]));
      if (v[38])
        chk(out_reg_idx == v[37:35], "R1 reg idx", 32'(out_reg_idx), 32'(v[37:35]));
      chk(out_ea == v[34:3], "R2-R8 address", out_ea, v[34:3]);
      chk(out_extra_len == v[2:0], "R2 R4 R7 extra length", 32'(out_extra_len), 32'(v[2:0]));
      last_ea = v[34:3]; last_len = v[2:0];
    end

    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid drops", 32'(out_valid), 32'd0);
    in_form = 8'h05; in_sidx = 8'h00; in_disp = 32'h5555_5555;
    repeat (2) @(negedge clk);
    chk(out_ea == last_ea, "R10 ea held", out_ea, last_ea);
    chk(out_extra_len == last_len, "R10 len held", 32'(out_extra_len), 32'(last_len));
    chk(out_valid == 1'b0, "R10 no valid", 32'(out_valid), 32'd0);

    rst_n = 1'b0; in_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R11 no accept in reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b0, "R9 ready low in reset", 32'(in_ready), 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 after re-reset", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule